// File: doc/BRIEF.md
# SIMD Integer ALU with Lane Carry Mask

This block is a multi-lane vector integer unit. Every lane takes two 32-bit operands, `a` (first source, lane slice of `in_src0`) and `b` (second source, lane slice of `in_src1`), plus its own bit of a shared carry mask. All lanes run the same opcode in the same cycle. Each lane returns a 32-bit result, and the six carry-producing operations return a per-lane carry or borrow bit that forms a new carry mask. An execution mask chooses which lanes commit.

The supported operations are:

- add, subtract and reverse subtract with carry or borrow out, and their carry-in forms;
- shifts that take the amount from `a` and the value from `b`, in 32-bit and 16-bit widths;
- bitwise AND, OR, XOR and XNOR;
- signed and unsigned minimum and maximum;
- 24-bit multiplies, returning either the low word or the high word of the product;
- a per-lane select driven by the carry mask.

Both input and output are valid/ready streams with a single register stage. A beat is accepted when `in_valid` and `in_ready` are both high. Its result appears on the next cycle with `out_valid` high, and it stays there unchanged until `out_ready` is seen high. `in_ready` equals `!out_valid || out_ready`, so a stalled consumer stalls the producer in the same cycle without any loss. A lane whose execution bit is 0 keeps the result value it last presented on `out_result`. Its outgoing carry bit is the incoming carry bit.

Top module: `simd_ialu`

## Requirements
- R1: An accepted beat (`in_valid && in_ready`) raises `out_valid` on the next clock. `in_ready` is `!out_valid || out_ready`. While `out_valid && !out_ready`, `out_valid`, `out_result` and `out_cmask` hold.
- R2: Opcode 0 (add with carry out): result is `(a+b) mod 2^32`. The carry bit is 1 when `a+b >= 2^32`.
- R3: Opcode 1 computes `a-b` with borrow 1 exactly when `b>a`. Opcode 2 computes `b-a` with borrow 1 exactly when `a>b`.
- R4: These opcodes use the lane's incoming carry bit `c`:
  - Opcode 3: result is `a+b+c`, with carry 1 when that sum is at least `2^32`.
  - Opcode 4: result is `a-b-c`, with borrow 1 when `b+c>a`.
  - Opcode 5: result is `b-a-c`, with borrow 1 when `a+c>b`.
- R5: Shift amounts come from `a`. The 32-bit shifts use `a[4:0]` and the 16-bit shifts use `a[3:0]`. Opcode 6 is `b<<a[4:0]` and opcode 9 is `{16'h0, (b[15:0]<<a[3:0])}` truncated to 16 bits.
- R6: The right shifts fill as follows:
  - Opcode 7: logical right shift of `b`, zero fill.
  - Opcode 8: arithmetic right shift of `b`, copying `b[31]`.
  - Opcodes 10 and 11: the same two shifts on `b[15:0]`, copying `b[15]` for the arithmetic one. The upper 16 result bits are 0.
- R7: The multiplies work on `a[23:0]` and `b[23:0]`:
  - Opcode 20: unsigned product, bits [31:0].
  - Opcode 21: signed (two's complement 24-bit) product, bits [31:0].
  - Opcode 22: unsigned product, bits [63:32].
  - Opcode 23: signed product sign-extended to 64 bits, bits [63:32].
- R8: The bitwise opcodes are 12 AND, 13 OR, 14 XOR and 15 XNOR. XNOR is `~(a^b)`.
- R9: The min/max opcodes are 16 signed min, 17 signed max, 18 unsigned min and 19 unsigned max.
- R10: Opcode 24 returns `b` when the lane's carry-mask bit is 1 and `a` when it is 0.
- R11: A lane with execution bit 0 keeps its previous `out_result` lane value, and its `out_cmask` bit equals its incoming carry bit.
- R12: Opcodes 6 to 24 pass each lane's incoming carry bit to `out_cmask` unchanged. Opcodes 25 to 31 do the same and give a zero result in executing lanes.
- R13: After reset, `out_valid`, `out_result` and `out_cmask` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Unit can take a beat |
| in_op | input | 5 | Opcode |
| in_src0 | input | LANES*32 | First operand per lane (shift amount for shifts) |
| in_src1 | input | LANES*32 | Second operand per lane |
| in_cmask | input | LANES | Incoming carry mask, one bit per lane |
| in_exec | input | LANES | Execution mask, one bit per lane |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | LANES*32 | Per-lane results |
| out_cmask | output | LANES | Outgoing carry mask |

## Verification
The bench builds the unit with the default of four lanes. This keeps all sixteen execution-mask patterns within a short sweep and lets different corner operands sit in neighbouring lanes of one beat. Every opcode, including the undefined ones, is driven with operands that provoke carry at exactly 2^32, equal-operand borrows, sign-bit fills and negative 24-bit products. A random phase then toggles `out_ready` so that stalls interleave with every operation.

// File: rtl/simd_ialu_pkg.sv
package simd_ialu_pkg;
  localparam int LW = 32;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD_CO    = 5'd0,
    OP_SUB_CO    = 5'd1,
    OP_RSUB_CO   = 5'd2,
    OP_ADD_CI    = 5'd3,
    OP_SUB_BI    = 5'd4,
    OP_RSUB_BI   = 5'd5,
    OP_SHL32     = 5'd6,
    OP_SHR32     = 5'd7,
    OP_SAR32     = 5'd8,
    OP_SHL16     = 5'd9,
    OP_SHR16     = 5'd10,
    OP_SAR16     = 5'd11,
    OP_AND       = 5'd12,
    OP_OR        = 5'd13,
    OP_XOR       = 5'd14,
    OP_XNOR      = 5'd15,
    OP_MIN_S     = 5'd16,
    OP_MAX_S     = 5'd17,
    OP_MIN_U     = 5'd18,
    OP_MAX_U     = 5'd19,
    OP_MUL_U24   = 5'd20,
    OP_MUL_S24   = 5'd21,
    OP_MULH_U24  = 5'd22,
    OP_MULH_S24  = 5'd23,
    OP_SELECT    = 5'd24
  } alu_op_e;
endpackage

// File: rtl/lane_addsub.sv
module lane_addsub
  import simd_ialu_pkg::*;
(
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic          cin,
  input  logic          do_sub,
  input  logic          swap,
  input  logic          use_cin,
  output logic [LW-1:0] sum,
  output logic          flag
);
  logic [LW-1:0] x, y, y_eff;
  logic          c_eff;
  logic [LW:0]   total;

  always_comb begin
    x     = swap ? b : a;
    y     = swap ? a : b;
    y_eff = do_sub ? ~y : y;
    if (use_cin) c_eff = do_sub ? ~cin : cin;
    else         c_eff = do_sub;
    total = {1'b0, x} + {1'b0, y_eff} + {{LW{1'b0}}, c_eff};
    sum   = total[LW-1:0];
    flag  = do_sub ? ~total[LW] : total[LW];
  end
endmodule

// File: rtl/lane_shift.sv
module lane_shift
  import simd_ialu_pkg::*;
(
  input  logic [LW-1:0] val,
  input  logic [4:0]    amt,
  input  logic          half,
  input  logic          right,
  input  logic          arith,
  output logic [LW-1:0] res
);
  localparam int HW = LW / 2;
  logic [HW-1:0] h, h_res;
  logic [LW-1:0] w_res;

  always_comb begin
    h = val[HW-1:0];
    if (!right)     h_res = h << amt[3:0];
    else if (arith) h_res = $signed(h) >>> amt[3:0];
    else            h_res = h >> amt[3:0];
    if (!right)     w_res = val << amt;
    else if (arith) w_res = $signed(val) >>> amt;
    else            w_res = val >> amt;
    res = half ? {{HW{1'b0}}, h_res} : w_res;
  end
endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import simd_ialu_pkg::*;
(
  input  alu_op_e       op,
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic          cin,
  output logic [LW-1:0] res,
  output logic          cout,
  output logic          wr_carry
);
  localparam int MW = 24;
  localparam int PW = 2 * MW;

  logic          as_sub, as_swap, as_cin;
  logic [LW-1:0] as_sum;
  logic          as_flag;
  logic          sh_half, sh_right, sh_arith;
  logic [LW-1:0] sh_res;
  logic [PW-1:0] prod_u;
  logic signed [PW-1:0] prod_s;
  logic signed [MW-1:0] a24, b24;

  always_comb begin
    as_sub  = (op == OP_SUB_CO) || (op == OP_RSUB_CO) || (op == OP_SUB_BI) || (op == OP_RSUB_BI);
    as_swap = (op == OP_RSUB_CO) || (op == OP_RSUB_BI);
    as_cin  = (op == OP_ADD_CI) || (op == OP_SUB_BI) || (op == OP_RSUB_BI);
    sh_half  = (op == OP_SHL16) || (op == OP_SHR16) || (op == OP_SAR16);
    sh_right = (op == OP_SHR32) || (op == OP_SAR32) || (op == OP_SHR16) || (op == OP_SAR16);
    sh_arith = (op == OP_SAR32) || (op == OP_SAR16);
  end

  lane_addsub u_addsub (
    .a(a), .b(b), .cin(cin), .do_sub(as_sub), .swap(as_swap), .use_cin(as_cin),
    .sum(as_sum), .flag(as_flag)
  );

  lane_shift u_shift (
    .val(b), .amt(a[4:0]), .half(sh_half), .right(sh_right), .arith(sh_arith),
    .res(sh_res)
  );

  always_comb begin
    a24    = a[MW-1:0];
    b24    = b[MW-1:0];
    prod_u = a[MW-1:0] * b[MW-1:0];
    prod_s = a24 * b24;
  end

  always_comb begin
    res      = '0;
    cout     = cin;
    wr_carry = 1'b0;
    case (op)
      OP_ADD_CO, OP_SUB_CO, OP_RSUB_CO, OP_ADD_CI, OP_SUB_BI, OP_RSUB_BI: begin
        res      = as_sum;
        cout     = as_flag;
        wr_carry = 1'b1;
      end
      OP_SHL32, OP_SHR32, OP_SAR32, OP_SHL16, OP_SHR16, OP_SAR16: res = sh_res;
      OP_AND:      res = a & b;
      OP_OR:       res = a | b;
      OP_XOR:      res = a ^ b;
      OP_XNOR:     res = ~(a ^ b);
      OP_MIN_S:    res = ($signed(a) < $signed(b)) ? a : b;
      OP_MAX_S:    res = ($signed(a) > $signed(b)) ? a : b;
      OP_MIN_U:    res = (a < b) ? a : b;
      OP_MAX_U:    res = (a > b) ? a : b;
      OP_MUL_U24:  res = prod_u[LW-1:0];
      OP_MUL_S24:  res = prod_s[LW-1:0];
      OP_MULH_U24: res = {{(2*LW-PW){1'b0}}, prod_u[PW-1:LW]};
      OP_MULH_S24: res = {{(2*LW-PW){prod_s[PW-1]}}, prod_s[PW-1:LW]};
      OP_SELECT:   res = cin ? b : a;
      default:     res = '0;
    endcase
  end
endmodule

// File: rtl/simd_ialu.sv
module simd_ialu
  import simd_ialu_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [OPW-1:0]      in_op,
  input  logic [LANES*LW-1:0] in_src0,
  input  logic [LANES*LW-1:0] in_src1,
  input  logic [LANES-1:0]    in_cmask,
  input  logic [LANES-1:0]    in_exec,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES*LW-1:0] out_result,
  output logic [LANES-1:0]    out_cmask
);
  localparam int BUSW = LANES * LW;

  logic [BUSW-1:0]  res_q;
  logic [LANES-1:0] cm_q;
  logic             vld_q;
  logic [BUSW-1:0]  lane_res;
  logic [LANES-1:0] lane_co;
  logic [LANES-1:0] lane_wc;
  logic             accept;
  alu_op_e          op_e;

  assign op_e     = alu_op_e'(in_op);
  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_alu u_alu (
      .op(op_e),
      .a(in_src0[g*LW +: LW]),
      .b(in_src1[g*LW +: LW]),
      .cin(in_cmask[g]),
      .res(lane_res[g*LW +: LW]),
      .cout(lane_co[g]),
      .wr_carry(lane_wc[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_q[g*LW +: LW] <= '0;
        cm_q[g]           <= 1'b0;
      end else if (accept) begin
        if (in_exec[g]) res_q[g*LW +: LW] <= lane_res[g*LW +: LW];
        cm_q[g] <= (in_exec[g] && lane_wc[g]) ? lane_co[g] : in_cmask[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         vld_q <= 1'b0;
    else if (accept)    vld_q <= 1'b1;
    else if (out_ready) vld_q <= 1'b0;
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;
  assign out_cmask  = cm_q;
endmodule

// File: rtl/simd_ialu_chk.sv
module simd_ialu_chk
  import simd_ialu_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [OPW-1:0]      in_op,
  input logic [LANES*LW-1:0] in_src0,
  input logic [LANES*LW-1:0] in_src1,
  input logic [LANES-1:0]    in_cmask,
  input logic [LANES-1:0]    in_exec,
  input logic                out_valid,
  input logic                out_ready,
  input logic [LANES*LW-1:0] out_result,
  input logic [LANES-1:0]    out_cmask
);
  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_cmask));
  // R1
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R12
  logic_carry_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 5'd12 |=> out_cmask == $past(in_cmask));

  for (genvar g = 0; g < LANES; g++) begin : g_exec
    // R11
    masked_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !in_exec[g] |=>
        out_result[g*LW +: LW] == $past(out_result[g*LW +: LW]) && out_cmask[g] == $past(in_cmask[g]));
  end
endmodule

bind simd_ialu simd_ialu_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/simd_ialu_test.sv
`timescale 1ns/1ps
module simd_ialu_test;
  localparam int LANES = 4;
  localparam int W = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [4:0] in_op = 0;
  logic [LANES*W-1:0] in_src0 = '0, in_src1 = '0;
  logic [LANES-1:0] in_cmask = '0, in_exec = '0;
  logic out_valid;
  logic out_ready = 1;
  logic [LANES*W-1:0] out_result;
  logic [LANES-1:0] out_cmask;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_res [LANES];
  logic [LANES-1:0] m_cm;
  bit m_valid;
  int last_op;
  logic [LANES-1:0] last_exec;

  simd_ialu #(.LANES(LANES)) uut (.*);

  always #10 clk = ~clk;

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not finish (actual hung, expected finish)");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic string tag_of(int op);
    if (op == 0) return "R2";
    if (op == 1 || op == 2) return "R3";
    if (op >= 3 && op <= 5) return "R4";
    if (op == 6 || op == 9) return "R5";
    if (op >= 6 && op <= 11) return "R6";
    if (op >= 12 && op <= 15) return "R8";
    if (op >= 16 && op <= 19) return "R9";
    if (op >= 20 && op <= 23) return "R7";
    if (op == 24) return "R10";
    return "R12";
  endfunction

  task automatic ref_lane(input int op, input logic [31:0] a, input logic [31:0] b, input bit c,
                          output logic [31:0] r, output bit co);
    longint unsigned ua = a, ub = b, s;
    longint sa, sb, p;
    logic [15:0] h;
    logic [63:0] pw;
    co = c;
    r = 0;
    sa = longint'($signed(a[23:0]));
    sb = longint'($signed(b[23:0]));
    h = b[15:0];
    case (op)
      0: begin s = ua + ub; r = s[31:0]; co = (s >= 64'h1_0000_0000); end
      1: begin r = a - b; co = (ub > ua); end
      2: begin r = b - a; co = (ua > ub); end
      3: begin s = ua + ub + c; r = s[31:0]; co = (s >= 64'h1_0000_0000); end
      4: begin r = a - b - c; co = (ub + c > ua); end
      5: begin r = b - a - c; co = (ua + c > ub); end
      6: r = b << a[4:0];
      7: r = b >> a[4:0];
      8: r = $signed(b) >>> a[4:0];
      9: begin h = h << a[3:0]; r = {16'h0, h}; end
      10: begin h = h >> a[3:0]; r = {16'h0, h}; end
      11: begin h = $signed(h) >>> a[3:0]; r = {16'h0, h}; end
      12: r = a & b;
      13: r = a | b;
      14: r = a ^ b;
      15: r = ~(a ^ b);
      16: r = (int'(a) < int'(b)) ? a : b;
      17: r = (int'(a) > int'(b)) ? a : b;
      18: r = (ua < ub) ? a : b;
      19: r = (ua > ub) ? a : b;
      20: begin pw = longint'(a[23:0]) * longint'(b[23:0]); r = pw[31:0]; end
      21: begin p = sa * sb; pw = p; r = pw[31:0]; end
      22: begin pw = longint'(a[23:0]) * longint'(b[23:0]); r = pw[63:32]; end
      23: begin p = sa * sb; pw = p; r = pw[63:32]; end
      24: r = c ? b : a;
      default: r = 0;
    endcase
  endtask

  task automatic step(input bit v, input int op, input logic [LANES*W-1:0] s0, input logic [LANES*W-1:0] s1,
                      input logic [LANES-1:0] cm, input logic [LANES-1:0] ex, input bit ordy);
    bit exp_rdy, acc;
    logic [31:0] r;
    bit co;
    in_valid = v; in_op = op[4:0]; in_src0 = s0; in_src1 = s1;
    in_cmask = cm; in_exec = ex; out_ready = ordy;
    #1;
    exp_rdy = !m_valid || ordy;
    tests++;
    if (in_ready !== exp_rdy) begin
      fails++;
      $display("FAIL R1 in_ready: actual %0b expected %0b", in_ready, exp_rdy);
    end
    acc = v && exp_rdy;
    if (acc) begin
      for (int l = 0; l < LANES; l++) begin
        ref_lane(op, s0[l*W +: W], s1[l*W +: W], cm[l], r, co);
        if (ex[l]) m_res[l] = r;
        m_cm[l] = (ex[l] && op <= 5) ? co : cm[l];
      end
      m_valid = 1;
      last_op = op;
      last_exec = ex;
    end else if (ordy) m_valid = 0;
    @(negedge clk);
    tests++;
    if (out_valid !== m_valid) begin
      fails++;
      $display("FAIL R1 out_valid: actual %0b expected %0b", out_valid, m_valid);
    end
    if (m_valid) begin
      for (int l = 0; l < LANES; l++) begin
        tests++;
        if (out_result[l*W +: W] !== m_res[l]) begin
          fails++;
          $display("FAIL %s lane %0d op %0d result: actual %h expected %h",
                   last_exec[l] ? tag_of(last_op) : "R11", l, last_op, out_result[l*W +: W], m_res[l]);
        end
      end
      tests++;
      if (out_cmask !== m_cm) begin
        fails++;
        $display("FAIL %s op %0d carry mask: actual %b expected %b",
                 (last_exec != '1) ? "R11" : tag_of(last_op), last_op, out_cmask, m_cm);
      end
    end
  endtask

  function automatic logic [31:0] corner(int i);
    case (i % 10)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      5: return 32'h00FF_FFFF;
      6: return 32'h0080_0000;
      7: return 32'h1234_5678;
      8: return 32'h0000_8F13;
      default: return 32'hFFFF_800C;
    endcase
  endfunction

  initial begin
    logic [LANES*W-1:0] a, b;
    for (int l = 0; l < LANES; l++) m_res[l] = 0;
    m_cm = 0; m_valid = 0; last_op = 0; last_exec = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R13 reset state
    tests++;
    if (out_valid !== 0 || out_result !== '0 || out_cmask !== '0) begin
      fails++;
      $display("FAIL R13 reset: actual v=%0b r=%h c=%b expected 0", out_valid, out_result, out_cmask);
    end
    // directed: every opcode, corner operand mixes
    for (int op = 0; op < 32; op++) begin
      for (int p = 0; p < 6; p++) begin
        for (int l = 0; l < LANES; l++) begin
          a[l*W +: W] = corner(p * LANES + l);
          b[l*W +: W] = corner(p * 3 + l * 7 + 1);
        end
        step(1, op, a, b, LANES'(p * 5 + 3), '1, 1);
      end
    end
    // R2 exact 2^32 boundary and R3 equal operands
    a = {32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0005, 32'hFFFF_FFFE};
    b = {32'h0000_0001, 32'h8000_0000, 32'h0000_0005, 32'h0000_0001};
    step(1, 0, a, b, '0, '1, 1);
    step(1, 1, a, b, '0, '1, 1);
    step(1, 2, a, b, '0, '1, 1);
    step(1, 3, a, b, '1, '1, 1);
    step(1, 4, a, b, '1, '1, 1);
    step(1, 5, a, b, '1, '1, 1);
    // R11 exec mask sweep
    for (int e = 0; e < 16; e++) begin
      for (int l = 0; l < LANES; l++) begin
        a[l*W +: W] = $urandom; b[l*W +: W] = $urandom;
      end
      step(1, e % 6, a, b, LANES'($urandom), LANES'(e), 1);
    end
    // R1 stalls: hold output then release
    step(1, 12, a, b, 4'b1010, '1, 0);
    step(1, 13, b, a, 4'b0101, '1, 0);
    step(0, 0, a, b, '0, '1, 0);
    step(1, 14, b, a, 4'b0011, '1, 1);
    step(0, 0, a, b, '0, '1, 1);
    // random mix with back-pressure
    for (int i = 0; i < 4000; i++) begin
      for (int l = 0; l < LANES; l++) begin
        a[l*W +: W] = ($urandom % 4 == 0) ? corner($urandom % 10) : $urandom;
        b[l*W +: W] = ($urandom % 4 == 0) ? corner($urandom % 10) : $urandom;
      end
      step(($urandom % 4) != 0, $urandom % 32, a, b, LANES'($urandom), LANES'($urandom),
           ($urandom % 3) != 0);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule